// File: doc/BRIEF.md
# Symmetric Peer Link Bring-Up Sequencer

This block runs the identification handshake at one end of a link whose two ends are equals. Neither end is a fixed master. Either end may open the exchange. Each end announces itself, asks its partner to identify, and answers the partner's own request. The link counts as usable only after both directions of the exchange have finished. Message traffic uses one valid-qualified port in each direction. Each message is a 2-bit kind plus an identifier field.

The local identity is built from three inputs: machine type, serial number and channel number. When this end starts the exchange and receives an answer, it latches the partner's identity and reports it. A timer bounds the wait for that answer. If the wait runs out, the sequencer goes back to announcing itself and drops all progress. Pulling `link_up` low clears all state, and so does the active-low reset.

Top module: `peer_link_init`

## Requirements
- R1: Message kinds are encoded READY=0, TRIGGER=1, COMMAND=2, RESPONSE=3. Identifier fields are packed as {type, serial, channel}, with type in the most significant bits. One cycle after `link_up` is sampled high while the sequencer is idle, `tx_valid` pulses for exactly one cycle with kind READY.
- R2: A received READY is answered in the next cycle with a TRIGGER.
- R3: A received TRIGGER is answered in the next cycle with a COMMAND carrying the local identifier, provided this end has not yet completed its own request and is not already waiting for a response.
- R4: A received COMMAND is answered in the next cycle with a RESPONSE carrying the local identifier. It also records that the partner's request has been served.
- R5: A RESPONSE received while waiting loads `partner_id`, raises `partner_valid`, and is followed in the next cycle by a TRIGGER.
- R6: A TRIGGER that arrives after this end has completed its own request, or while it is waiting for a response, produces no transmission.
- R7: `link_oper` is high only when both the own request and the served partner request have completed, whichever order they finished in.
- R8: After TMO_CYC cycles of waiting with no RESPONSE, both completion records are cleared. One cycle later a READY is sent again. A RESPONSE that arrives in the last waiting cycle is still accepted.
- R9: While `link_up` is low or reset is asserted, no message is sent, received messages are ignored, `link_oper` and `partner_valid` are low, and `partner_id` reads zero.
- R10: READY and TRIGGER messages carry an all-zero identifier field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Physical link present; low clears all state |
| local_type | input | TYPE_W | Local machine type |
| local_serial | input | SER_W | Local serial number |
| local_chan | input | CHAN_W | Local channel number |
| rx_valid | input | 1 | Incoming message valid |
| rx_kind | input | 2 | Incoming message kind |
| rx_id | input | TYPE_W+SER_W+CHAN_W | Incoming identifier field |
| tx_valid | output | 1 | Outgoing message valid (one-cycle pulse) |
| tx_kind | output | 2 | Outgoing message kind |
| tx_id | output | TYPE_W+SER_W+CHAN_W | Outgoing identifier field |
| partner_id | output | TYPE_W+SER_W+CHAN_W | Latched partner identifier |
| partner_valid | output | 1 | Partner identifier held |
| link_oper | output | 1 | Both directions complete |

## Verification
The assertions assume that the port delivers at most one message per cycle. They also assume that the local identity inputs stay constant while the link is up, because the response check compares `tx_id` against the identity seen one cycle earlier. The stimulus respects both points. It presents every message as a single-cycle pulse separated by idle cycles, and it changes the identity only while `link_up` is low. The sweeps cover both completion orders, several identity patterns, a response landing on the final waiting cycle, and a full timeout followed by a fresh bring-up.

// File: rtl/peer_init_pkg.sv
package peer_init_pkg;

    typedef enum logic [1:0] {
        MSG_READY = 2'd0,
        MSG_TRIG  = 2'd1,
        MSG_CMD   = 2'd2,
        MSG_RSP   = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        LS_OFF    = 2'd0,
        LS_LISTEN = 2'd1,
        LS_AWAIT  = 2'd2
    } link_st_e;

endpackage

// File: rtl/peer_rsp_timer.sv
module peer_rsp_timer #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(TMO_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = run && (cnt_q == LAST);

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= LAST));

    // R8
    cnt_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt_q == '0));

endmodule

// File: rtl/peer_id_store.sv
module peer_id_store #(
    parameter int ID_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            load,
    input  logic [ID_W-1:0] id_in,
    output logic [ID_W-1:0] id_out,
    output logic            held
);
    typedef struct packed {
        logic            held;
        logic [ID_W-1:0] id;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else if (load) begin
            st_d.held = 1'b1;
            st_d.id   = id_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign id_out = st_q.id;
    assign held   = st_q.held;

    // R9
    clr_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!held && id_out == '0));

    // R5
    load_captures_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (held && id_out == $past(id_in)));

endmodule

// File: rtl/peer_link_init.sv
module peer_link_init
    import peer_init_pkg::*;
#(
    parameter int TYPE_W  = 8,
    parameter int SER_W   = 16,
    parameter int CHAN_W  = 8,
    parameter int TMO_CYC = 64
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            link_up,
    input  logic [TYPE_W-1:0]               local_type,
    input  logic [SER_W-1:0]                local_serial,
    input  logic [CHAN_W-1:0]               local_chan,
    input  logic                            rx_valid,
    input  logic [1:0]                      rx_kind,
    input  logic [TYPE_W+SER_W+CHAN_W-1:0]  rx_id,
    output logic                            tx_valid,
    output logic [1:0]                      tx_kind,
    output logic [TYPE_W+SER_W+CHAN_W-1:0]  tx_id,
    output logic [TYPE_W+SER_W+CHAN_W-1:0]  partner_id,
    output logic                            partner_valid,
    output logic                            link_oper
);
    localparam int ID_W = TYPE_W + SER_W + CHAN_W;

    typedef struct packed {
        link_st_e        st;
        logic            init_done;
        logic            resp_done;
        logic            tx_valid;
        logic [1:0]      tx_kind;
        logic [ID_W-1:0] tx_id;
    } ctl_t;

    ctl_t r_d, r_q;

    logic [ID_W-1:0] own_id;
    logic            tmo_exp;
    logic            id_load;
    logic            id_clr;
    logic            rsp_in;
    msg_kind_e       kind_in;

    assign own_id  = {local_type, local_serial, local_chan};
    assign kind_in = msg_kind_e'(rx_kind);
    assign rsp_in  = rx_valid && (kind_in == MSG_RSP);

    peer_rsp_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (r_q.st == LS_AWAIT),
        .expired (tmo_exp)
    );

    peer_id_store #(.ID_W(ID_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (id_clr),
        .load   (id_load),
        .id_in  (rx_id),
        .id_out (partner_id),
        .held   (partner_valid)
    );

    always_comb begin
        r_d          = r_q;
        r_d.tx_valid = 1'b0;
        r_d.tx_kind  = MSG_READY;
        r_d.tx_id    = '0;
        id_load      = 1'b0;
        id_clr       = 1'b0;
        if (!link_up) begin
            r_d.st        = LS_OFF;
            r_d.init_done = 1'b0;
            r_d.resp_done = 1'b0;
            id_clr        = 1'b1;
        end else if (r_q.st == LS_OFF) begin
            r_d.st       = LS_LISTEN;
            r_d.tx_valid = 1'b1;
            r_d.tx_kind  = MSG_READY;
        end else if (tmo_exp && !rsp_in) begin
            r_d.st        = LS_OFF;
            r_d.init_done = 1'b0;
            r_d.resp_done = 1'b0;
            id_clr        = 1'b1;
        end else if (rx_valid) begin
            unique case (kind_in)
                MSG_READY: begin
                    r_d.tx_valid = 1'b1;
                    r_d.tx_kind  = MSG_TRIG;
                end
                MSG_TRIG: begin
                    if (!r_q.init_done && r_q.st == LS_LISTEN) begin
                        r_d.st       = LS_AWAIT;
                        r_d.tx_valid = 1'b1;
                        r_d.tx_kind  = MSG_CMD;
                        r_d.tx_id    = own_id;
                    end
                end
                MSG_CMD: begin
                    r_d.resp_done = 1'b1;
                    r_d.tx_valid  = 1'b1;
                    r_d.tx_kind   = MSG_RSP;
                    r_d.tx_id     = own_id;
                end
                MSG_RSP: begin
                    if (r_q.st == LS_AWAIT) begin
                        r_d.st        = LS_LISTEN;
                        r_d.init_done = 1'b1;
                        r_d.tx_valid  = 1'b1;
                        r_d.tx_kind   = MSG_TRIG;
                        id_load       = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign tx_valid  = r_q.tx_valid;
    assign tx_kind   = r_q.tx_kind;
    assign tx_id     = r_q.tx_id;
    assign link_oper = r_q.init_done && r_q.resp_done;

    // R2
    ready_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && r_q.st != LS_OFF && !tmo_exp && rx_valid && rx_kind == 2'd0)
        |=> (tx_valid && tx_kind == 2'd1 && tx_id == '0));

    // R3
    cmd_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_kind == 2'd2) |-> ($past(rx_valid) && $past(rx_kind) == 2'd1));

    // R4
    rsp_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && r_q.st != LS_OFF && !tmo_exp && rx_valid && rx_kind == 2'd2)
        |=> (tx_valid && tx_kind == 2'd3 && tx_id == $past(own_id)));

    // R6
    trig_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && r_q.init_done && rx_valid && rx_kind == 2'd1) |=> !tx_valid);

    // R7
    oper_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_oper) |-> ($past(rx_valid) && $past(rx_kind) >= 2'd2));

    // R9
    down_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (!tx_valid && !link_oper && !partner_valid));

endmodule

// File: tb/sim_peer_link_init.sv
module sim_peer_link_init;
    localparam int TW = 8, SW = 16, CW = 8, TMO = 8;
    localparam int IW = TW + SW + CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          link_up = 1'b0;
    logic [TW-1:0] l_type = '0;
    logic [SW-1:0] l_ser = '0;
    logic [CW-1:0] l_chan = '0;
    logic          rx_valid = 1'b0;
    logic [1:0]    rx_kind = '0;
    logic [IW-1:0] rx_id = '0;
    logic          tx_valid;
    logic [1:0]    tx_kind;
    logic [IW-1:0] tx_id;
    logic [IW-1:0] partner_id;
    logic          partner_valid;
    logic          link_oper;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    peer_link_init #(.TYPE_W(TW), .SER_W(SW), .CHAN_W(CW), .TMO_CYC(TMO)) u0 (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .local_type(l_type), .local_serial(l_ser), .local_chan(l_chan),
        .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_id(rx_id),
        .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_id(tx_id),
        .partner_id(partner_id), .partner_valid(partner_valid), .link_oper(link_oper)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic exp_tx(input string tag, input bit v, input logic [1:0] k, input logic [IW-1:0] id);
        if (!v) chk(tag, 64'(tx_valid), 64'd0);
        else    chk(tag, 64'({tx_valid, tx_kind, tx_id}), 64'({1'b1, k, id}));
    endtask

    task automatic send(input logic [1:0] k, input logic [IW-1:0] id);
        rx_valid = 1'b1;
        rx_kind  = k;
        rx_id    = id;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_id    = '0;
    endtask

    task automatic bring_up();
        link_up = 1'b1;
        @(negedge clk);
        exp_tx("R1 ready on link up", 1'b1, 2'd0, '0);
        @(negedge clk);
        exp_tx("R1 ready single pulse", 1'b0, 2'd0, '0);
    endtask

    task automatic take_down();
        link_up = 1'b0;
        @(negedge clk);
        chk("R9 oper cleared", 64'(link_oper), 64'd0);
        chk("R9 partner cleared", 64'({partner_valid, partner_id}), 64'd0);
        send(2'd2, '0);
        exp_tx("R9 rx ignored when down", 1'b0, 2'd0, '0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [IW-1:0] own, peer;
        repeat (3) @(negedge clk);
        chk("R9 reset tx", 64'(tx_valid), 64'd0);
        chk("R9 reset oper", 64'({link_oper, partner_valid}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 idle while down", 64'(tx_valid), 64'd0);

        for (int pat = 0; pat < 8; pat++) begin
            l_type = TW'(8'h10 + pat);
            l_ser  = SW'(16'hA000 ^ (pat * 16'h1111));
            l_chan = CW'(pat * 3 + 1);
            own    = {l_type, l_ser, l_chan};
            peer   = {TW'(pat + 5), SW'(pat * 257 + 9), CW'(8'hF0 - pat)};
            bring_up();
            send(2'd0, '0);
            exp_tx("R2 trigger reply", 1'b1, 2'd1, '0);
            chk("R10 trigger id zero", 64'(tx_id), 64'd0);
            if (pat[0]) begin
                send(2'd2, peer);
                exp_tx("R4 response reply", 1'b1, 2'd3, own);
                chk("R7 not yet oper", 64'(link_oper), 64'd0);
            end
            send(2'd1, '0);
            exp_tx("R3 command reply", 1'b1, 2'd2, own);
            send(2'd1, '0);
            exp_tx("R6 trigger while waiting", 1'b0, 2'd0, '0);
            if (pat[1]) begin
                repeat (TMO - 3) @(negedge clk);
            end
            send(2'd3, peer);
            exp_tx("R5 trigger after response", 1'b1, 2'd1, '0);
            chk("R5 partner stored", 64'({partner_valid, partner_id}), 64'({1'b1, peer}));
            send(2'd1, '0);
            exp_tx("R6 trigger after done", 1'b0, 2'd0, '0);
            if (!pat[0]) begin
                chk("R7 one side only", 64'(link_oper), 64'd0);
                send(2'd2, peer);
                exp_tx("R4 response reply", 1'b1, 2'd3, own);
            end
            chk("R7 both done", 64'(link_oper), 64'd1);
            take_down();
        end

        // response in the last waiting cycle is accepted
        bring_up();
        send(2'd1, '0);
        exp_tx("R3 command", 1'b1, 2'd2, own);
        repeat (TMO - 1) @(negedge clk);
        send(2'd3, peer);
        exp_tx("R8 late response accepted", 1'b1, 2'd1, '0);
        take_down();

        // timeout clears both records and re-announces
        bring_up();
        send(2'd1, '0);
        exp_tx("R3 command", 1'b1, 2'd2, own);
        send(2'd2, peer);
        exp_tx("R4 response while waiting", 1'b1, 2'd3, own);
        for (int k = 2; k <= TMO; k++) begin
            @(negedge clk);
            exp_tx("R8 silent before timeout", 1'b0, 2'd0, '0);
        end
        @(negedge clk);
        exp_tx("R8 ready after timeout", 1'b1, 2'd0, '0);
        send(2'd1, '0);
        exp_tx("R3 command again", 1'b1, 2'd2, own);
        send(2'd3, peer);
        exp_tx("R5 trigger", 1'b1, 2'd1, '0);
        chk("R8 answered record cleared", 64'({partner_valid, link_oper}), 64'b10);
        send(2'd2, peer);
        exp_tx("R4 response", 1'b1, 2'd3, own);
        chk("R7 oper after both", 64'(link_oper), 64'd1);
        take_down();

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule